// File: doc/BRIEF.md
# Bus Write Buffer Status Timer

This block produces the status flags that describe an external-bus write buffer as the CPU sees it. It keeps no data. Each word written to the external bus pulses a write strobe. The strobe arms a set of deadline timers or pushes them further out. Those deadlines in turn raise and drop individual bits of an 8-bit status word. A free-running time base, counted in clock cycles, is supplied from outside, and all deadlines are held as absolute values of that time base.

Three bits of the status word are driven:

- The busy bit rises as soon as a write occurs and stays up while the queued writes drain.
- The delayed-busy bit rises some time after the first write of a burst and falls well after the burst ends.
- The tail bit follows the same on/off pattern as the delayed-busy bit, with its own delays.

Back-to-back writes add time to deadlines that are still pending. The three bits therefore describe overlapping windows that behave like a queue. Every timer is re-evaluated on every clock cycle, so the status word is always current.

Top module: `wrbuf_status_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the status word is 0x00, all three flag outputs are low, and no timer is pending. The first write after reset therefore arms every timer as if it were idle.
- R2: The busy bit (status bit 5, also `busyFlag`) is high in the cycle after the clock edge at which `wrStrobe` is sampled high.
- R3: Consider a write sampled at time-base value T. If the busy timer is idle, its deadline becomes T+BUSY_HOLD. If it is pending, its deadline moves later by BUSY_HOLD. The busy bit drops after the edge at which the time base reaches the deadline.
- R4: Consider a write at time T. If the delayed-busy on-timer is idle, its deadline becomes T+LATE_ON. If it is pending, it is left unchanged. The delayed-busy bit (status bit 4, also `lateBusyFlag`) rises after the edge at which the time base reaches that deadline.
- R5: On a write, an idle delayed-busy off-timer gets a deadline equal to the on-timer deadline after that write plus LATE_OFF. A pending off-timer moves later by LATE_OFF. The delayed-busy bit drops after the edge at which the time base reaches the deadline.
- R6: The tail bit (status bit 0, also `tailFlag`) follows the on/off rules of R4 and R5, using TAIL_ON and TAIL_OFF in place of LATE_ON and LATE_OFF.
- R7: A timer is due once the time base has reached its deadline. The time base minus the deadline is taken as a TIME_W-bit signed value, and the timer is due when that value is zero or more. At a due edge the timer applies its action and becomes idle. A write sampled at that same edge sees the timer idle and re-arms it from the current time, so a busy window that is refilled exactly at its deadline shows no gap.
- R8: If the on-timer and the off-timer of the same bit are due at the same edge, the bit is low afterwards (the off action wins).
- R9: The status word is 8 bits wide. Bit 5 is busy, bit 4 is delayed-busy and bit 0 is tail. Bits 7, 6, 3, 2 and 1 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStrobe | input | 1 | One-cycle pulse per word written to the external bus |
| timeBase | input | TIME_W | Free-running cycle count used for all deadlines |
| statusWord | output | 8 | Status word read by the CPU |
| busyFlag | output | 1 | Busy bit (status bit 5) |
| lateBusyFlag | output | 1 | Delayed-busy bit (status bit 4) |
| tailFlag | output | 1 | Tail bit (status bit 0) |

## Verification
The bench builds the block with TIME_W = 16 and keeps BUSY_HOLD, LATE_ON and LATE_OFF at their defaults of 60, 60 and 160. It sets TAIL_ON to 40 and TAIL_OFF to 20. Because the tail off-delay is then shorter than its on-delay, a second write issued exactly when the first tail on-event fires puts the re-armed on deadline and the extended off deadline on the same tick, which reaches the override case of R8. The short tail delays also let refill-at-deadline and burst-stacking scenarios finish within a few hundred cycles. The bench checks them both cycle by cycle and through the total high time of each flag.

// File: rtl/wbs_pkg.sv
`timescale 1ns/1ps
package wbs_pkg;

  localparam int STAT_W   = 8;
  localparam int BUSY_POS = 5;
  localparam int LATE_POS = 4;
  localparam int TAIL_POS = 0;

  // Strobes from the timer control to the status datapath, one edge each.
  typedef struct packed {
    logic setBusy;
    logic clrBusy;
    logic setLate;
    logic clrLate;
    logic setTail;
    logic clrTail;
  } wbs_strobe_t;

endpackage

// File: rtl/wbs_hold.sv
`timescale 1ns/1ps
// Single extendable deadline: loaded fresh when idle, stacked when pending.
module wbs_hold #(
  parameter int TIME_W = 16,
  parameter int HOLD   = 60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [TIME_W-1:0] timeBase,
  output logic              fire
);
  localparam logic [TIME_W-1:0] HOLD_T = TIME_W'(HOLD);

  logic              holdAct;
  logic [TIME_W-1:0] holdDue;
  logic [TIME_W-1:0] gap;
  logic              actPost;

  assign gap     = timeBase - holdDue;
  assign fire    = holdAct & ~gap[TIME_W-1];
  assign actPost = holdAct & ~fire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdAct <= 1'b0;
      holdDue <= '0;
    end else if (wrStrobe) begin
      holdAct <= 1'b1;
      holdDue <= actPost ? holdDue + HOLD_T : timeBase + HOLD_T;
    end else begin
      holdAct <= actPost;
    end
  end

  // R3: every write leaves the busy deadline pending
  p_hold_armed_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> holdAct);

  // R7: a due timer with no write in the same cycle goes idle
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !wrStrobe) |=> !holdAct);

endmodule

// File: rtl/wbs_pair.sv
`timescale 1ns/1ps
// On/off deadline pair for one delayed status bit.
module wbs_pair #(
  parameter int TIME_W  = 16,
  parameter int ON_DLY  = 60,
  parameter int OFF_DLY = 160
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [TIME_W-1:0] timeBase,
  output logic              fireOn,
  output logic              fireOff
);
  localparam logic [TIME_W-1:0] ON_T  = TIME_W'(ON_DLY);
  localparam logic [TIME_W-1:0] OFF_T = TIME_W'(OFF_DLY);

  logic              onAct, offAct;
  logic [TIME_W-1:0] onDue, offDue;
  logic [TIME_W-1:0] onGap, offGap;
  logic              onPost, offPost;
  logic [TIME_W-1:0] onNext;

  assign onGap   = timeBase - onDue;
  assign offGap  = timeBase - offDue;
  assign fireOn  = onAct  & ~onGap[TIME_W-1];
  assign fireOff = offAct & ~offGap[TIME_W-1];
  assign onPost  = onAct  & ~fireOn;
  assign offPost = offAct & ~fireOff;
  // On deadline as it stands after a write this cycle.
  assign onNext  = onPost ? onDue : timeBase + ON_T;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onAct  <= 1'b0;
      offAct <= 1'b0;
      onDue  <= '0;
      offDue <= '0;
    end else if (wrStrobe) begin
      onAct  <= 1'b1;
      offAct <= 1'b1;
      onDue  <= onNext;
      offDue <= offPost ? offDue + OFF_T : onNext + OFF_T;
    end else begin
      onAct  <= onPost;
      offAct <= offPost;
    end
  end

  // R4: a pending on deadline is never moved by a write
  p_on_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (onAct && !fireOn) |=> (onAct && $stable(onDue)));

  // R5: every write leaves the off deadline pending
  p_off_armed_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> offAct);

  // R7: a due off timer with no write goes idle
  p_off_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fireOff && !wrStrobe) |=> !offAct);

endmodule

// File: rtl/wbs_ctrl.sv
`timescale 1ns/1ps
// Timer control: owns every deadline and emits per-edge set/clear strobes.
module wbs_ctrl
  import wbs_pkg::*;
#(
  parameter int TIME_W    = 16,
  parameter int BUSY_HOLD = 60,
  parameter int LATE_ON   = 60,
  parameter int LATE_OFF  = 160,
  parameter int TAIL_ON   = 100,
  parameter int TAIL_OFF  = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [TIME_W-1:0] timeBase,
  output wbs_strobe_t       strobes
);
  localparam int PAIRS = 2;

  logic             busyFire;
  logic [PAIRS-1:0] pairOn;
  logic [PAIRS-1:0] pairOff;

  wbs_hold #(.TIME_W(TIME_W), .HOLD(BUSY_HOLD)) uBusy (
    .clk      (clk),
    .rstN     (rstN),
    .wrStrobe (wrStrobe),
    .timeBase (timeBase),
    .fire     (busyFire)
  );

  // Index 0 drives the delayed-busy bit, index 1 the tail bit.
  for (genvar g = 0; g < PAIRS; g++) begin : gPair
    localparam int ON_V  = (g == 0) ? LATE_ON  : TAIL_ON;
    localparam int OFF_V = (g == 0) ? LATE_OFF : TAIL_OFF;
    wbs_pair #(.TIME_W(TIME_W), .ON_DLY(ON_V), .OFF_DLY(OFF_V)) uPair (
      .clk      (clk),
      .rstN     (rstN),
      .wrStrobe (wrStrobe),
      .timeBase (timeBase),
      .fireOn   (pairOn[g]),
      .fireOff  (pairOff[g])
    );
  end

  always_comb begin
    strobes         = '0;
    strobes.setBusy = wrStrobe;
    strobes.clrBusy = busyFire;
    strobes.setLate = pairOn[0];
    strobes.clrLate = pairOff[0];
    strobes.setTail = pairOn[1];
    strobes.clrTail = pairOff[1];
  end

endmodule

// File: rtl/wbs_stat.sv
`timescale 1ns/1ps
// Status datapath: holds the three live bits and builds the status word.
module wbs_stat
  import wbs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wbs_strobe_t       strobes,
  output logic [STAT_W-1:0] statusWord,
  output logic              busyQ,
  output logic              lateQ,
  output logic              tailQ
);

  // Evaluation order: busy clear, then on-set, then off-clear; a write sets busy last.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      lateQ <= 1'b0;
      tailQ <= 1'b0;
    end else begin
      busyQ <= strobes.setBusy | (busyQ & ~strobes.clrBusy);
      lateQ <= ~strobes.clrLate & (strobes.setLate | lateQ);
      tailQ <= ~strobes.clrTail & (strobes.setTail | tailQ);
    end
  end

  always_comb begin
    statusWord           = '0;
    statusWord[BUSY_POS] = busyQ;
    statusWord[LATE_POS] = lateQ;
    statusWord[TAIL_POS] = tailQ;
  end

  // R2: a write shows as busy on the next cycle
  p_busy_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setBusy |=> busyQ);

  // R3: busy only drops after its deadline fired
  p_busy_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> $past(strobes.clrBusy));

  // R4: delayed-busy only rises from its on event
  p_late_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lateQ) |-> $past(strobes.setLate));

  // R6: tail only rises from its on event
  p_tail_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tailQ) |-> $past(strobes.setTail));

  // R8: coincident on and off leave the bit low
  p_late_off_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setLate && strobes.clrLate) |=> !lateQ);

  p_tail_off_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.setTail && strobes.clrTail) |=> !tailQ);

endmodule

// File: rtl/wrbuf_status_timer.sv
`timescale 1ns/1ps
module wrbuf_status_timer
  import wbs_pkg::*;
#(
  parameter int TIME_W    = 16,
  parameter int BUSY_HOLD = 60,
  parameter int LATE_ON   = 60,
  parameter int LATE_OFF  = 160,
  parameter int TAIL_ON   = 100,
  parameter int TAIL_OFF  = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [TIME_W-1:0] timeBase,
  output logic [STAT_W-1:0] statusWord,
  output logic              busyFlag,
  output logic              lateBusyFlag,
  output logic              tailFlag
);

  wbs_strobe_t strobes;

  wbs_ctrl #(
    .TIME_W    (TIME_W),
    .BUSY_HOLD (BUSY_HOLD),
    .LATE_ON   (LATE_ON),
    .LATE_OFF  (LATE_OFF),
    .TAIL_ON   (TAIL_ON),
    .TAIL_OFF  (TAIL_OFF)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrStrobe (wrStrobe),
    .timeBase (timeBase),
    .strobes  (strobes)
  );

  wbs_stat uStat (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .statusWord (statusWord),
    .busyQ      (busyFlag),
    .lateQ      (lateBusyFlag),
    .tailQ      (tailFlag)
  );

endmodule

// File: tb/tb_wrbuf_status_timer.sv
`timescale 1ns/1ps
module tb_wrbuf_status_timer;

  localparam int TIME_W    = 16;
  localparam int BUSY_HOLD = 60;
  localparam int LATE_ON   = 60;
  localparam int LATE_OFF  = 160;
  localparam int TAIL_ON   = 40;
  localparam int TAIL_OFF  = 20;
  localparam int SCEN_LEN  = 600;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrStrobe = 1'b0;
  logic [TIME_W-1:0] timeBase = '0;
  logic [7:0]        statusWord;
  logic              busyFlag, lateBusyFlag, tailFlag;

  wrbuf_status_timer #(
    .TIME_W(TIME_W), .BUSY_HOLD(BUSY_HOLD), .LATE_ON(LATE_ON),
    .LATE_OFF(LATE_OFF), .TAIL_ON(TAIL_ON), .TAIL_OFF(TAIL_OFF)
  ) dut (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .timeBase(timeBase),
    .statusWord(statusWord), .busyFlag(busyFlag),
    .lateBusyFlag(lateBusyFlag), .tailFlag(tailFlag)
  );

  always #10 clk = ~clk;  // 50 MHz

  int total = 0;
  int bad   = 0;
  int tick  = 0;
  bit finished = 1'b0;
  int busyCnt = 0, lateCnt = 0, tailCnt = 0;

  typedef struct {
    logic [7:0] st;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  // Reference state, kept from the requirements as absolute deadlines.
  bit mA5, mAo4, mAf4, mAo0, mAf0;
  int mD5, mDo4, mDf4, mDo0, mDf0;
  bit mS5, mS4, mS0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (tick %0d)", req, act, exp, tick);
    end
  endtask

  task automatic modelEdge(input bit rst, input bit wr, input int t);
    bit f5, fo4, ff4, fo0, ff0;
    if (rst) begin
      {mA5, mAo4, mAf4, mAo0, mAf0, mS5, mS4, mS0} = '0;
      return;
    end
    f5  = mA5  && t >= mD5;
    fo4 = mAo4 && t >= mDo4;
    ff4 = mAf4 && t >= mDf4;
    fo0 = mAo0 && t >= mDo0;
    ff0 = mAf0 && t >= mDf0;
    if (f5)  mS5 = 0;
    if (fo4) mS4 = 1;
    if (ff4) mS4 = 0;
    if (fo0) mS0 = 1;
    if (ff0) mS0 = 0;
    if (wr)  mS5 = 1;
    if (f5)  mA5 = 0;
    if (fo4) mAo4 = 0;
    if (ff4) mAf4 = 0;
    if (fo0) mAo0 = 0;
    if (ff0) mAf0 = 0;
    if (wr) begin
      mD5 = mA5 ? mD5 + BUSY_HOLD : t + BUSY_HOLD;  mA5 = 1;
      if (!mAo4) begin mDo4 = t + LATE_ON; mAo4 = 1; end
      mDf4 = mAf4 ? mDf4 + LATE_OFF : mDo4 + LATE_OFF;  mAf4 = 1;
      if (!mAo0) begin mDo0 = t + TAIL_ON; mAo0 = 1; end
      mDf0 = mAf0 ? mDf0 + TAIL_OFF : mDo0 + TAIL_OFF;  mAf0 = 1;
    end
  endtask

  // Driver: one call per clock edge; pushes what that edge must produce.
  task automatic step(input bit rst, input bit wr, input string tag);
    expItem_t it;
    @(negedge clk);
    rstN     = ~rst;
    wrStrobe = wr;
    timeBase = tick[TIME_W-1:0];
    modelEdge(rst, wr, tick);
    it.st = 8'h00;
    it.st[5] = mS5;
    it.st[4] = mS4;
    it.st[0] = mS0;
    it.tag = tag;
    expQ.push_back(it);
    tick++;
  endtask

  task automatic settle();
    @(posedge clk);
    #5;
  endtask

  task automatic clearCounts();
    busyCnt = 0; lateCnt = 0; tailCnt = 0;
  endtask

  // Monitor: samples away from the edge and compares with the scoreboard.
  always begin
    @(posedge clk);
    #2;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check(statusWord === it.st, it.tag, statusWord, it.st);
      check((statusWord & 8'hCE) == 8'h00, "R9 spare bits", statusWord & 8'hCE, 0);
      if (busyFlag)     busyCnt++;
      if (lateBusyFlag) lateCnt++;
      if (tailFlag)     tailCnt++;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", tick, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0, "R1 reset");
    step(1'b0, 1'b0, "R1 after reset");
    settle();
    check(statusWord == 8'h00, "R1 status after reset", statusWord, 0);
    check({busyFlag, lateBusyFlag, tailFlag} == 3'b000, "R1 flags", {busyFlag, lateBusyFlag, tailFlag}, 0);

    // Scenario 1: one write from idle (R2, R3, R4, R5, R6)
    clearCounts();
    step(1'b0, 1'b1, "R3 single write");
    settle();
    check(busyFlag == 1'b1, "R2 busy next cycle", busyFlag, 1);
    for (int k = 1; k < SCEN_LEN; k++) step(1'b0, 1'b0, "R3 single write");
    settle();
    check(busyCnt == 60,  "R3 busy window",  busyCnt, 60);
    check(lateCnt == 160, "R5 late window",  lateCnt, 160);
    check(tailCnt == 20,  "R6 tail window",  tailCnt, 20);
    check(statusWord == 8'h00, "R5 idle after drain", statusWord, 0);

    // Scenario 2: second write when the tail on event fires (R4, R8)
    clearCounts();
    for (int k = 0; k < SCEN_LEN; k++) step(1'b0, (k == 0) || (k == 40), "R8 coincident");
    settle();
    check(busyCnt == 120, "R3 busy extended", busyCnt, 120);
    check(lateCnt == 320, "R4 on kept while pending", lateCnt, 320);
    check(tailCnt == 40,  "R8 off wins at same tick", tailCnt, 40);

    // Scenario 3: refill exactly at the busy deadline (R7)
    clearCounts();
    for (int k = 0; k < SCEN_LEN; k++) step(1'b0, (k == 0) || (k == 60), "R7 refill at deadline");
    settle();
    check(busyCnt == 120, "R7 busy no gap", busyCnt, 120);
    check(lateCnt == 320, "R7 late window", lateCnt, 320);
    check(tailCnt == 40,  "R7 tail re-armed", tailCnt, 40);

    // Scenario 4: burst of three back-to-back writes (R3, R5, R6)
    clearCounts();
    for (int k = 0; k < SCEN_LEN; k++) step(1'b0, k < 3, "R5 burst");
    settle();
    check(busyCnt == 180, "R3 burst busy", busyCnt, 180);
    check(lateCnt == 480, "R5 burst late", lateCnt, 480);
    check(tailCnt == 60,  "R6 burst tail", tailCnt, 60);

    // Scenario 5: reset in the middle of a burst clears everything (R1)
    clearCounts();
    for (int k = 0; k < 30; k++) step(1'b0, k < 2, "R1 pre-reset");
    step(1'b1, 1'b0, "R1 mid reset");
    step(1'b0, 1'b0, "R1 post reset");
    settle();
    check(statusWord == 8'h00, "R1 cleared mid burst", statusWord, 0);
    clearCounts();
    for (int k = 0; k < SCEN_LEN; k++) step(1'b0, 1'b0, "R1 stays idle");
    settle();
    check(busyCnt + lateCnt + tailCnt == 0, "R1 no pending timer", busyCnt + lateCnt + tailCnt, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule